// File: doc/BRIEF.md
# Cascadable four-bit universal counter

This block is a synchronous binary counter, four bits wide by default. It can load a parallel value, count up, count down or hold. Two select lines choose the operation. An active-low carry input gates both counting directions. Every bit of the count changes on the same rising clock edge, and the clock is never gated. Stopping the count is done only through the select lines and the carry input.

An active-low carry output is combinational. It is low in load mode. In a counting mode it is low when the count sits at its terminal value and the carry input is also low. Wider counters are built by chaining stages: wire each stage's carry output to the next stage's carry input, and share the clock and select lines. The upper stage then steps in the same cycle that the lower stage wraps.

A synchronous active-high reset clears the count to zero and takes priority over every mode. There is no data stream at this block's edge, so every pin is a plain control or data pin with no handshake.

Top module: `hex_univ_counter`

## Requirements
- R1: With mode code {sel_hi, sel_lo} = 2'b00 (load), the count equals load_val after the next rising edge, whatever cin_n is.
- R2: With code 2'b01 (up) and cin_n = 0, each rising edge adds one to the count, and 4'hF wraps to 4'h0.
- R3: With code 2'b10 (down) and cin_n = 0, each rising edge subtracts one from the count, and 4'h0 wraps to 4'hF.
- R4: In code 2'b01 or 2'b10 with cin_n = 1, the count keeps its value.
- R5: In code 2'b11, the count keeps its value for both levels of cin_n.
- R6: cout_n is 0 whenever the code is 2'b00.
- R7: In code 2'b01, cout_n is 0 exactly when cin_n = 0 and count = 4'hF. In code 2'b10, cout_n is 0 exactly when cin_n = 0 and count = 4'h0.
- R8: cout_n is 1 whenever the code is 2'b11.
- R9: cout_n follows a change of cin_n, the select lines or the count within the same cycle, with no clock edge between cause and effect.
- R10: While rst = 1 at a rising edge, the count becomes 0, and this overrides every mode including load.
- R11: Two stages with the low stage's cout_n driving the high stage's cin_n count as one 8-bit counter, up through 8'hFF to 8'h00 and down through 8'h00 to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, never gated |
| rst | input | 1 | Synchronous active-high reset, clears the count |
| sel_hi | input | 1 | Upper bit of the mode code |
| sel_lo | input | 1 | Lower bit of the mode code |
| cin_n | input | 1 | Active-low carry input, enables counting |
| load_val | input | WIDTH | Value taken in load mode |
| cnt | output | WIDTH | Current count |
| cout_n | output | 1 | Active-low carry output, combinational |

## Verification
The bench sweeps every one of the sixteen count values against all eight pairs of mode code and carry input. For each pair it checks the carry output before the edge and the count after it, so a wrong terminal value, a missed carry gate or a swapped direction shows up at a specific value. Long runs of up and down counting through the wrap points tell modular arithmetic apart from saturating arithmetic. A load issued partway through a count separates a synchronous load from one that takes effect before the edge. A two-stage chain stepped through 8'hFF and 8'h00 shows whether the carry output arrives in the same cycle, because a registered carry would make the high stage step one count late.

// File: rtl/huc_pkg.sv
package huc_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } mode_e;
endpackage

// File: rtl/huc_mode_decode.sv
module huc_mode_decode
  import huc_pkg::*;
(
  input  logic  sel_hi,
  input  logic  sel_lo,
  input  logic  cin_n,
  output mode_e mode,
  output logic  step_en
);
  always_comb begin
    mode    = mode_e'({sel_hi, sel_lo});
    step_en = 1'b0;
    if ((mode == MODE_UP || mode == MODE_DOWN) && !cin_n) step_en = 1'b1;
  end
endmodule

// File: rtl/huc_count_reg.sv
module huc_count_reg
  import huc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic             step_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (mode == MODE_LOAD)                  cnt_d = load_val;
    else if (step_en && mode == MODE_UP)    cnt_d = cnt_q + ONE;
    else if (step_en && mode == MODE_DOWN)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R10: reset clears the count
  p_reset_clear_r10: assert property (@(posedge clk) rst |=> cnt == '0);
  // R1: synchronous load
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_LOAD |=> cnt == $past(load_val));
  // R2: increment with wrap
  p_up_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UP && step_en) |=> cnt == WIDTH'($past(cnt) + ONE));
  // R3: decrement with wrap
  p_down_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DOWN && step_en) |=> cnt == WIDTH'($past(cnt) - ONE));
  // R4, R5: hold conditions
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_LOAD && !step_en) |=> $stable(cnt));
endmodule

// File: rtl/huc_carry_gen.sv
module huc_carry_gen
  import huc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic             cin_n,
  input  logic [WIDTH-1:0] cnt,
  output logic             cout_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic at_top, at_bot;

  always_comb begin
    at_top = (cnt == TOP);
    at_bot = (cnt == BOT);
    unique case (mode)
      MODE_LOAD: cout_n = 1'b0;
      MODE_UP:   cout_n = !(at_top && !cin_n);
      MODE_DOWN: cout_n = !(at_bot && !cin_n);
      default:   cout_n = 1'b1;
    endcase
  end

  // R6: carry low while loading
  p_cout_load_r6: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_LOAD |-> !cout_n);
  // R8: carry high in unconditional hold
  p_cout_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_HOLD |-> cout_n);
  // R7: carry in a counting mode needs an enabled terminal count
  p_cout_term_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_UP || mode == MODE_DOWN) && !cout_n) |->
      (!cin_n && ((mode == MODE_UP) ? cnt == TOP : cnt == BOT)));
endmodule

// File: rtl/hex_univ_counter.sv
module hex_univ_counter
  import huc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             cin_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt,
  output logic             cout_n
);
  mode_e mode;
  logic  step_en;

  huc_mode_decode u_dec (
    .sel_hi(sel_hi), .sel_lo(sel_lo), .cin_n(cin_n),
    .mode(mode), .step_en(step_en)
  );

  huc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .mode(mode), .step_en(step_en),
    .load_val(load_val), .cnt(cnt)
  );

  huc_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .clk(clk), .rst(rst), .mode(mode), .cin_n(cin_n),
    .cnt(cnt), .cout_n(cout_n)
  );

  // R4: a raised carry input freezes a counting stage
  p_cin_gate_r4: assert property (@(posedge clk) disable iff (rst)
    ({sel_hi, sel_lo} != 2'b00 && cin_n) |=> $stable(cnt));
endmodule

// File: tb/hex_univ_counter_tb_top.sv
module hex_univ_counter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_hi = 1'b0, sel_lo = 1'b0, cin_n = 1'b1;
  logic [3:0] load_val = 4'h0;
  logic [3:0] cnt, cnt_hi;
  logic cout_n, cout_hi_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hex_univ_counter #(.WIDTH(4)) dut_i (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .cin_n(cin_n),
    .load_val(load_val), .cnt(cnt), .cout_n(cout_n)
  );

  hex_univ_counter #(.WIDTH(4)) dut_hi (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo), .cin_n(cout_n),
    .load_val(load_val), .cnt(cnt_hi), .cout_n(cout_hi_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_in(input logic [1:0] code, input logic c, input logic [3:0] d);
    {sel_hi, sel_lo} = code; cin_n = c; load_val = d;
  endtask

  function automatic logic [3:0] ref_next(input logic [1:0] code, input logic c,
                                          input logic [3:0] q, input logic [3:0] d);
    if (code == 2'b00) return d;
    if (code == 2'b01 && !c) return q + 4'h1;
    if (code == 2'b10 && !c) return q - 4'h1;
    return q;
  endfunction

  function automatic logic ref_cout(input logic [1:0] code, input logic c, input logic [3:0] q);
    if (code == 2'b00) return 1'b0;
    if (code == 2'b01) return !(!c && q == 4'hF);
    if (code == 2'b10) return !(!c && q == 4'h0);
    return 1'b1;
  endfunction

  task automatic t_reset();
    set_in(2'b00, 1'b0, 4'h9); rst = 1'b1; tick();
    chk("R10 reset beats load", cnt, 0);
    rst = 1'b0;
  endtask

  task automatic t_sweep();
    for (int q = 0; q < 16; q++)
      for (int code = 0; code < 4; code++)
        for (int c = 0; c < 2; c++) begin
          set_in(2'b00, 1'b1, 4'(q)); tick();
          chk("R1 load", cnt, q);
          set_in(2'(code), c[0], 4'(15 - q)); #1;
          chk(code == 0 ? "R6 cout load" : code == 3 ? "R8 cout hold" : "R7 R9 cout",
              cout_n, ref_cout(2'(code), c[0], 4'(q)));
          tick();
          chk(code == 0 ? "R1 load" : code == 3 ? "R5 hold" : c ? "R4 cin hold" : "R2 R3 step",
              cnt, ref_next(2'(code), c[0], 4'(q), 4'(15 - q)));
        end
  endtask

  task automatic t_wrap_runs();
    logic [3:0] e;
    set_in(2'b00, 1'b0, 4'hC); tick(); e = 4'hC;
    set_in(2'b01, 1'b0, 4'h0);
    for (int i = 0; i < 20; i++) begin tick(); e = e + 4'h1; chk("R2 up run", cnt, e); end
    set_in(2'b10, 1'b0, 4'h0);
    for (int i = 0; i < 20; i++) begin tick(); e = e - 4'h1; chk("R3 down run", cnt, e); end
    // mid-count load
    set_in(2'b00, 1'b0, 4'h6); #1;
    chk("R1 no load before edge", cnt, e);
    tick(); chk("R1 mid-count load", cnt, 6);
  endtask

  task automatic t_cascade();
    logic [7:0] e;
    set_in(2'b00, 1'b0, 4'hE); tick(); e = 8'hEE;
    chk("R11 cascade load", {cnt_hi, cnt}, e);
    set_in(2'b01, 1'b0, 4'h0);
    for (int i = 0; i < 40; i++) begin tick(); e = e + 8'h1; chk("R11 cascade up", {cnt_hi, cnt}, e); end
    set_in(2'b00, 1'b0, 4'h1); tick(); e = 8'h11;
    set_in(2'b10, 1'b0, 4'h0);
    for (int i = 0; i < 40; i++) begin tick(); e = e - 8'h1; chk("R11 cascade down", {cnt_hi, cnt}, e); end
  endtask

  initial begin
    #2;
    t_reset();
    t_sweep();
    t_wrap_runs();
    t_cascade();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule